// File: doc/BRIEF.md
# Receive Descriptor Ring Engine

This block moves incoming Ethernet frames into memory. Frames arrive one byte per handshake on a stream, and the frame length is presented with the first byte. The engine walks a ring of 8-byte descriptors in memory. Each descriptor names a buffer. The engine fills each buffer up to a programmable size and then moves on to the next descriptor. Behind the payload it writes a CRC-32 that it computes as the bytes arrive. It then writes every used descriptor back with its empty bit cleared, its byte count filled in, and, in the final descriptor of a frame, the last bit and any length error flags.

A receive-active flag tells the frame source whether the engine will take a frame. After each frame the engine reads the next descriptor and sets the flag only if that descriptor is empty. While the flag is clear, an offered frame is held off: ready stays low and memory is not touched. Software refreshes the flag by strobing `act_wr` after it has handed descriptors back. Dropping `enable` stops the engine and returns the ring pointer to the ring base.

Descriptor layout, little-endian words. Word 0 holds the byte count in bits 15:0 and the flags in bits 31:16. Word 1 holds the buffer address.

Top module: `rx_ring_dma`

## Requirements
- R1: While reset is asserted, and after it, `rx_active`, `rx_ready`, `mem_valid`, `irq_rxb` and `irq_rxf` are all 0 until software strobes `act_wr` with `enable` high.
- R2: The stored frame is the payload followed by 4 CRC bytes. The CRC is the reflected CRC-32 (polynomial 0xEDB88320, register preset to all ones, result complemented) taken over the payload. It is stored most significant byte first.
- R3: When the stored length exceeds the `MAX_FRAME` parameter, the frame is cut to `MAX_FRAME` bytes and the final descriptor gets both the truncated flag (bit 16) and the length-violation flag (bit 21). Payload bytes beyond the cut are still taken from the stream and discarded.
- R4: When the stored length after any cut exceeds `max_len`, the final descriptor gets the length-violation flag (bit 21) alone.
- R5: Each buffer receives at most `buf_size` bytes, and CRC bytes may be split across two buffers. Every filled descriptor is written back with the empty bit (bit 31) cleared, the wrap bit (bit 29) kept, and its byte count. It pulses `irq_rxb` once. The final one also gets the last bit (bit 27) and the error flags, and pulses `irq_rxf`.
- R6: If a descriptor met in the middle of a frame is not empty, the rest of the frame is consumed from the stream without being written, `irq_rxf` is not pulsed, and `rx_active` ends up 0.
- R7: After each frame, `rx_active` equals the empty bit of the descriptor at the new ring pointer. While `rx_active` is 0, `rx_ready` stays low and an offered frame is not taken.
- R8: With `shift16` set, two zero bytes come before the payload in the first buffer only. They count toward the stored length, the byte counts and the cut.
- R9: After a descriptor with the wrap bit set, the pointer reloads from `ring_base`. Otherwise it advances by 8 bytes.
- R10: An `act_wr` strobe while enabled and idle re-reads the descriptor at the ring pointer and sets `rx_active` to its empty bit.
- R11: While `enable` is low, `rx_active` is 0 one cycle later, the pointer is held at `ring_base`, and no frame is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Engine enable |
| act_wr | input | 1 | Strobe: re-read the current descriptor to refresh `rx_active` |
| ring_base | input | AW | Byte address of the first descriptor in the ring |
| buf_size | input | LW | Largest byte count per buffer (non-zero) |
| max_len | input | LW | Length above which the length-violation flag is set |
| shift16 | input | 1 | Insert two zero bytes ahead of the payload |
| rx_valid | input | 1 | Stream byte valid |
| rx_ready | output | 1 | Stream byte accepted at this edge when valid |
| rx_data | input | 8 | Stream byte |
| rx_len | input | LW | Payload length, stable while the frame is offered |
| mem_valid | output | 1 | Memory access this cycle |
| mem_write | output | 1 | 1 = write, 0 = read |
| mem_byte | output | 1 | Write only `mem_wdata[7:0]` at `mem_addr` |
| mem_addr | output | AW | Byte address |
| mem_wdata | output | 32 | Write data, little-endian word |
| mem_rdata | input | 32 | Read data, valid in the same cycle as the read |
| rx_active | output | 1 | Engine will take a frame |
| irq_rxb | output | 1 | One-cycle pulse per buffer written back |
| irq_rxf | output | 1 | One-cycle pulse per completed frame |

## Verification
The frame path is tried with six patterns, each built to separate one rule:
- A short frame in one buffer isolates the CRC value and its byte order.
- A buffer size that splits the CRC across two descriptors shows that the split point follows the count of stored bytes.
- A padded frame shows that the two zero bytes land only in the first buffer.
- A frame just over `max_len` sets the length-violation flag alone.
- Two frames over `MAX_FRAME` show the cut. In one, whole payload bytes are drained. In the other, the cut falls inside the CRC because of the pad.

Directed sequences cover the rest:
- Filling the whole ring shows the wrap and the refusal that follows.
- A busy descriptor mid-frame shows the drop.
- A disable cycle shows that the pointer returns to the ring base.

// File: rtl/rx_ring_dma.sv
module rx_ring_dma #(
  parameter int AW         = 32,
  parameter int LW         = 16,
  parameter int MAX_FRAME  = 2047,
  parameter int DESC_BYTES = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          act_wr,
  input  logic [AW-1:0] ring_base,
  input  logic [LW-1:0] buf_size,
  input  logic [LW-1:0] max_len,
  input  logic          shift16,
  input  logic          rx_valid,
  output logic          rx_ready,
  input  logic [7:0]    rx_data,
  input  logic [LW-1:0] rx_len,
  output logic          mem_valid,
  output logic          mem_write,
  output logic          mem_byte,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic [31:0]   mem_rdata,
  output logic          rx_active,
  output logic          irq_rxb,
  output logic          irq_rxf
);
  localparam int F_EMPTY = 15;
  localparam int F_WRAP  = 13;
  localparam int F_LAST  = 11;
  localparam int F_LONG  = 5;
  localparam int F_TRUNC = 0;

  typedef enum logic [2:0] {S_IDLE, S_POLL, S_DESC, S_BUF, S_DATA, S_WB, S_DRAIN} state_t;
  state_t st;

  logic [AW-1:0] ptr, baddr;
  logic [15:0]   dflags, new_flags;
  logic [LW-1:0] len_q, total_q, pos, used, left, chunk;
  logic          pad_q, trunc_q, long_q;
  logic [31:0]   crc, crc_fin;
  logic [7:0]    out_byte;

  function automatic logic [31:0] crc_step(logic [31:0] c, logic [7:0] d);
    logic [31:0] r = c ^ {24'd0, d};
    for (int i = 0; i < 8; i++) r = r[0] ? ((r >> 1) ^ 32'hEDB88320) : (r >> 1);
    return r;
  endfunction

  logic [LW:0]   raw_total;
  logic [LW-1:0] cut_total, pad_n, crc_idx, remain, take;
  logic          over_max, over_lim, in_pad, in_data, stall, last_wb;

  assign raw_total = {1'b0, rx_len} + (LW+1)'(shift16 ? 6 : 4);
  assign over_max  = raw_total > (LW+1)'(MAX_FRAME);
  assign cut_total = over_max ? LW'(MAX_FRAME) : raw_total[LW-1:0];
  assign over_lim  = cut_total > max_len;

  assign pad_n   = pad_q ? LW'(2) : '0;
  assign in_pad  = pos < pad_n;
  assign in_data = !in_pad && ((pos - pad_n) < len_q);
  assign crc_idx = pos - pad_n - len_q;
  assign remain  = total_q - pos;
  assign take    = (remain < buf_size) ? remain : buf_size;
  assign stall   = (st == S_DATA) && in_data && !rx_valid;
  assign last_wb = (pos == total_q);
  assign crc_fin = ~crc;

  always_comb begin
    case (crc_idx[1:0])
      2'd0:    out_byte = crc_fin[31:24];
      2'd1:    out_byte = crc_fin[23:16];
      2'd2:    out_byte = crc_fin[15:8];
      default: out_byte = crc_fin[7:0];
    endcase
    if (in_pad)       out_byte = 8'h00;
    else if (in_data) out_byte = rx_data;
  end

  always_comb begin
    new_flags = dflags & ~(16'h1 << F_EMPTY);
    if (last_wb)
      new_flags = new_flags | (16'h1 << F_LAST) | (16'(trunc_q) << F_TRUNC) | (16'(long_q) << F_LONG);
  end

  always_comb begin
    mem_valid = 1'b0;
    mem_write = 1'b0;
    mem_byte  = 1'b0;
    mem_addr  = ptr;
    mem_wdata = '0;
    case (st)
      S_POLL, S_DESC: mem_valid = 1'b1;
      S_BUF: begin
        mem_valid = 1'b1;
        mem_addr  = ptr + AW'(4);
      end
      S_DATA: begin
        mem_valid = !stall;
        mem_write = 1'b1;
        mem_byte  = 1'b1;
        mem_addr  = baddr + AW'(chunk - left);
        mem_wdata = {24'd0, out_byte};
      end
      S_WB: begin
        mem_valid = 1'b1;
        mem_write = 1'b1;
        mem_wdata = {new_flags, 16'(chunk)};
      end
      default: ;
    endcase
  end

  assign rx_ready = ((st == S_DATA) && in_data) || ((st == S_DRAIN) && (used != len_q));
  assign irq_rxb  = (st == S_WB);
  assign irq_rxf  = (st == S_WB) && last_wb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      ptr <= '0;
      baddr <= '0;
      dflags <= '0;
      len_q <= '0;
      total_q <= '0;
      pos <= '0;
      used <= '0;
      left <= '0;
      chunk <= '0;
      pad_q <= 1'b0;
      trunc_q <= 1'b0;
      long_q <= 1'b0;
      crc <= '1;
      rx_active <= 1'b0;
    end else if (!enable) begin
      st <= S_IDLE;
      rx_active <= 1'b0;
      ptr <= ring_base;
    end else begin
      case (st)
        S_IDLE:
          if (act_wr) st <= S_POLL;
          else if (rx_active && rx_valid) begin
            len_q   <= rx_len;
            total_q <= cut_total;
            pad_q   <= shift16;
            trunc_q <= over_max;
            long_q  <= over_max || over_lim;
            pos     <= '0;
            used    <= '0;
            crc     <= '1;
            st      <= S_DESC;
          end
        S_POLL: begin
          rx_active <= mem_rdata[16+F_EMPTY];
          st <= S_IDLE;
        end
        S_DESC:
          if (mem_rdata[16+F_EMPTY]) begin
            dflags <= mem_rdata[31:16];
            st <= S_BUF;
          end else st <= S_DRAIN;
        S_BUF: begin
          baddr <= mem_rdata[AW-1:0];
          chunk <= take;
          left  <= take;
          st    <= S_DATA;
        end
        S_DATA:
          if (!stall) begin
            pos  <= pos + LW'(1);
            left <= left - LW'(1);
            if (in_data) begin
              used <= used + LW'(1);
              crc  <= crc_step(crc, rx_data);
            end
            if (left == LW'(1)) st <= S_WB;
          end
        S_WB: begin
          ptr <= dflags[F_WRAP] ? ring_base : ptr + AW'(DESC_BYTES);
          if (!last_wb) st <= S_DESC;
          else if (used == len_q) st <= S_POLL;
          else st <= S_DRAIN;
        end
        S_DRAIN:
          if (used == len_q) st <= S_POLL;
          else if (rx_valid) used <= used + LW'(1);
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_wb_clears_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_write && !mem_byte) |-> !mem_wdata[16+F_EMPTY]);

  assert_frame_pulse_last_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_rxf |-> (irq_rxb && mem_wdata[16+F_LAST]));

  assert_active_after_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_active) |-> $past(mem_valid && !mem_write));

  assert_ready_needs_active_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ready |-> rx_active);

  assert_disable_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !rx_active);
endmodule

// File: tb/rx_ring_dma_tb_top.sv
module rx_ring_dma_tb_top;
  localparam int AW = 16, LW = 16, MAXF = 64, NDESC = 4;
  localparam int RING = 'h100, BUFS = 'h400;
  localparam logic [15:0] FE = 16'h8000, FW = 16'h2000, FL = 16'h0800, FLG = 16'h0020, FTR = 16'h0001;
  // fields: len, buf_size, shift16, max_len, seed
  localparam logic [47:0] VEC [0:5] = '{
    {8'd12, 8'd64, 8'd0, 16'd1518, 8'h11},
    {8'd18, 8'd10, 8'd0, 16'd1518, 8'h40},
    {8'd10, 8'd8,  8'd1, 16'd1518, 8'h77},
    {8'd20, 8'd16, 8'd0, 16'd20,   8'h05},
    {8'd70, 8'd64, 8'd0, 16'd1518, 8'h23},
    {8'd61, 8'd64, 8'd1, 16'd1518, 8'h3c}};

  logic clk = 0, rst_n = 0, enable = 0, act_wr = 0, shift16 = 0, rx_valid = 0;
  logic [AW-1:0] ring_base = AW'(RING);
  logic [LW-1:0] buf_size = 64, max_len = 1518, rx_len = 0;
  logic [7:0] rx_data = 0;
  logic rx_ready, mem_valid, mem_write, mem_byte, rx_active, irq_rxb, irq_rxf;
  logic [AW-1:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata;

  always #5 clk = ~clk;

  rx_ring_dma #(.AW(AW), .LW(LW), .MAX_FRAME(MAXF)) dut_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .act_wr(act_wr), .ring_base(ring_base),
    .buf_size(buf_size), .max_len(max_len), .shift16(shift16), .rx_valid(rx_valid),
    .rx_ready(rx_ready), .rx_data(rx_data), .rx_len(rx_len), .mem_valid(mem_valid),
    .mem_write(mem_write), .mem_byte(mem_byte), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .rx_active(rx_active), .irq_rxb(irq_rxb), .irq_rxf(irq_rxf));

  logic [7:0] mem [0:4095];
  logic host_we = 0;
  logic [11:0] host_a = 0;
  logic [7:0] host_d = 0;
  wire [11:0] ma = mem_addr[11:0];
  assign mem_rdata = {mem[ma+12'd3], mem[ma+12'd2], mem[ma+12'd1], mem[ma]};
  always @(posedge clk) begin
    if (host_we) mem[host_a] <= host_d;
    else if (mem_valid && mem_write) begin
      if (mem_byte) mem[ma] <= mem_wdata[7:0];
      else begin
        mem[ma] <= mem_wdata[7:0];
        mem[ma+12'd1] <= mem_wdata[15:8];
        mem[ma+12'd2] <= mem_wdata[23:16];
        mem[ma+12'd3] <= mem_wdata[31:24];
      end
    end
  end

  int nrxb = 0, nrxf = 0;
  always @(negedge clk) begin
    if (irq_rxb) nrxb++;
    if (irq_rxf) nrxf++;
  end

  int errors = 0, checks = 0;
  logic [7:0] expb [0:255];
  int exp_total;
  bit exp_tr, exp_lg;

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors + 1, checks + 1);
    $finish;
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(int seed, int k);
    return 8'(seed + 7 * k + k / 5);
  endfunction

  function automatic logic [31:0] ref_crc(int len, int seed);
    logic [31:0] c = 32'hFFFFFFFF;
    logic [7:0] b;
    for (int k = 0; k < len; k++) begin
      b = pat(seed, k);
      for (int i = 0; i < 8; i++)
        if (c[0] ^ b[i]) c = (c >> 1) ^ 32'hEDB88320;
        else c = c >> 1;
    end
    return ~c;
  endfunction

  function automatic logic [31:0] peek32(int a);
    return {mem[a+3], mem[a+2], mem[a+1], mem[a]};
  endfunction

  task automatic poke(input int a, input logic [7:0] d);
    @(negedge clk);
    host_we = 1; host_a = 12'(a); host_d = d;
  endtask

  task automatic poke32(input int a, input logic [31:0] w);
    for (int i = 0; i < 4; i++) poke(a + i, w[8*i +: 8]);
  endtask

  task automatic setup(input int bs, input int ml, input bit sh, input logic [3:0] emask);
    @(negedge clk);
    enable = 0; buf_size = LW'(bs); max_len = LW'(ml); shift16 = sh;
    for (int i = 0; i < NDESC; i++) begin
      poke32(RING + 8 * i, {(emask[i] ? FE : 16'h0) | (i == NDESC - 1 ? FW : 16'h0), 16'h0});
      poke32(RING + 8 * i + 4, 32'(BUFS + 64 * i));
    end
    for (int i = 0; i < 64 * NDESC; i++) poke(BUFS + i, 8'hEE);
    @(negedge clk); host_we = 0;
    @(negedge clk); enable = 1; act_wr = 1;
    @(negedge clk); act_wr = 0;
    repeat (3) @(negedge clk);
  endtask

  task automatic send_frame(input int len, input int seed, output bit ok);
    int g;
    ok = 1;
    rx_len = LW'(len);
    for (int k = 0; k < len; k++) begin
      @(negedge clk);
      rx_data = pat(seed, k); rx_valid = 1; g = 0;
      while (!rx_ready && g < 200) begin @(negedge clk); g++; end
      if (g >= 200) ok = 0;
    end
    @(negedge clk); rx_valid = 0;
    repeat (30) @(negedge clk);
  endtask

  task automatic build_exp(input int len, input int seed, input bit sh, input int ml);
    logic [31:0] c;
    int p;
    c = ref_crc(len, seed);
    p = 0;
    if (sh) begin expb[0] = 0; expb[1] = 0; p = 2; end
    for (int k = 0; k < len; k++) begin expb[p] = pat(seed, k); p++; end
    expb[p] = c[31:24]; expb[p+1] = c[23:16]; expb[p+2] = c[15:8]; expb[p+3] = c[7:0];
    p = p + 4;
    exp_tr = p > MAXF;
    exp_total = exp_tr ? MAXF : p;
    exp_lg = exp_tr || exp_total > ml;
  endtask

  task automatic check_frame(input string tag, input int bs, output int nbuf);
    int rem, pos, d, ch, bad;
    logic [15:0] ef;
    rem = exp_total; pos = 0; d = 0;
    while (rem > 0) begin
      ch = rem < bs ? rem : bs;
      ef = (d == NDESC - 1 ? FW : 16'h0) |
           (rem == ch ? (FL | (exp_lg ? FLG : 16'h0) | (exp_tr ? FTR : 16'h0)) : 16'h0);
      check(peek32(RING + 8 * d) == {ef, 16'(ch)}, {tag, " descriptor word R5"},
            peek32(RING + 8 * d), {ef, 16'(ch)});
      bad = 0;
      for (int j = 0; j < ch; j++) if (mem[BUFS + 64 * d + j] !== expb[pos + j]) bad++;
      check(bad == 0, {tag, " buffer bytes"}, 32'(bad), 0);
      pos += ch; rem -= ch; d++;
    end
    nbuf = d;
  endtask

  initial begin
    int b0, f0, nb, cnt;
    bit ok;
    logic [7:0] vl, vb, vs, vseed;
    logic [15:0] vm;
    string tag;

    repeat (3) @(negedge clk);
    check({rx_active, rx_ready, mem_valid, irq_rxb, irq_rxf} == 0, "R1 outputs in reset",
          32'({rx_active, rx_ready, mem_valid, irq_rxb, irq_rxf}), 0);
    rst_n = 1; enable = 1;
    repeat (3) @(negedge clk);
    check({rx_active, rx_ready, mem_valid} == 0, "R1 idle after reset",
          32'({rx_active, rx_ready, mem_valid}), 0);

    for (int v = 0; v < 6; v++) begin
      {vl, vb, vs, vm, vseed} = VEC[v];
      case (v)
        0: tag = "R2 crc single buffer";
        1: tag = "R5 crc straddle";
        2: tag = "R8 pad first buffer";
        3: tag = "R4 length flag only";
        4: tag = "R3 truncate drain";
        default: tag = "R3 R8 truncate padded";
      endcase
      setup(int'(vb), int'(vm), vs[0], 4'hF);
      check(rx_active == 1, {tag, " R10 active after strobe"}, 32'(rx_active), 1);
      b0 = nrxb; f0 = nrxf;
      build_exp(int'(vl), int'(vseed), vs[0], int'(vm));
      send_frame(int'(vl), int'(vseed), ok);
      check(ok, {tag, " stream accepted"}, 32'(ok), 1);
      check_frame(tag, int'(vb), nb);
      check(nrxb - b0 == nb, {tag, " R5 buffer pulses"}, 32'(nrxb - b0), 32'(nb));
      check(nrxf - f0 == 1, {tag, " R5 frame pulse"}, 32'(nrxf - f0), 1);
      check(rx_active == 1, {tag, " R7 next empty"}, 32'(rx_active), 1);
    end

    // R9 wrap, R7 refusal, R10 refresh
    setup(8, 1518, 0, 4'hF);
    build_exp(28, 9, 0, 1518);
    send_frame(28, 9, ok);
    check_frame("R9 full ring", 8, nb);
    check(rx_active == 0, "R7 ring full after wrap", 32'(rx_active), 0);
    b0 = nrxb; cnt = 0;
    rx_len = 4; rx_valid = 1;
    for (int i = 0; i < 15; i++) begin @(negedge clk); if (rx_ready) cnt++; end
    rx_valid = 0;
    check(cnt == 0, "R7 refused while inactive", 32'(cnt), 0);
    check(nrxb == b0, "R7 no write while inactive", 32'(nrxb - b0), 0);
    poke32(RING, {FE, 16'h0});
    @(negedge clk); host_we = 0; act_wr = 1;
    @(negedge clk); act_wr = 0;
    repeat (3) @(negedge clk);
    check(rx_active == 1, "R10 refresh after release", 32'(rx_active), 1);
    build_exp(3, 21, 0, 1518);
    send_frame(3, 21, ok);
    check_frame("R9 wrapped to base", 8, nb);
    check(rx_active == 0, "R7 next descriptor busy", 32'(rx_active), 0);

    // R6 busy descriptor mid-frame
    setup(8, 1518, 0, 4'b1011);
    b0 = nrxb; f0 = nrxf;
    send_frame(20, 3, ok);
    check(ok, "R6 rest of frame consumed", 32'(ok), 1);
    check(peek32(RING) == 32'h0000_0008, "R6 first descriptor", peek32(RING), 32'h8);
    check(peek32(RING + 8) == 32'h0000_0008, "R6 second descriptor", peek32(RING + 8), 32'h8);
    check(peek32(RING + 16) == 32'h0, "R6 busy descriptor untouched", peek32(RING + 16), 0);
    check(mem[BUFS + 128] == 8'hEE, "R6 dropped bytes not written", 32'(mem[BUFS + 128]), 32'hEE);
    check(nrxf == f0, "R6 no frame pulse", 32'(nrxf - f0), 0);
    check(nrxb - b0 == 2, "R6 buffer pulses", 32'(nrxb - b0), 2);
    check(rx_active == 0, "R6 inactive after drop", 32'(rx_active), 0);

    // R11 disable returns pointer to base
    setup(64, 1518, 0, 4'hF);
    send_frame(5, 1, ok);
    @(negedge clk); enable = 0;
    @(negedge clk);
    check(rx_active == 0, "R11 inactive when disabled", 32'(rx_active), 0);
    rx_len = 4; rx_valid = 1; cnt = 0;
    for (int i = 0; i < 10; i++) begin @(negedge clk); if (rx_ready || mem_valid) cnt++; end
    rx_valid = 0;
    check(cnt == 0, "R11 no activity when disabled", 32'(cnt), 0);
    poke32(RING, {FE, 16'h0});
    @(negedge clk); host_we = 0; enable = 1; act_wr = 1;
    @(negedge clk); act_wr = 0;
    repeat (3) @(negedge clk);
    build_exp(6, 2, 0, 1518);
    send_frame(6, 2, ok);
    check(peek32(RING) == {FL, 16'd10}, "R11 pointer back at base", peek32(RING), {FL, 16'd10});

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule